// File: doc/BRIEF.md
# Gated Clock Output Divider

This block is the last stage of a programmable clock generator, before the pad. It takes two source clocks, a synthesized PLL clock and a raw reference clock. Both arrive as tick strobes in the block's system clock domain, and each tick marks one edge (one half-period) of that source. A configuration bit chooses which source is used. The chosen ticks then drive a power-of-two post-divider, which produces a 50 % duty output clock.

The divided clock is gated by an active-low control pin. Two configuration bits set how the pin acts:

- **Disable mode.** In output-enable mode the divider keeps running while the output is off. In power-down mode the source path is halted, and the output returns only after the PLL reports lock again.
- **Disable timing.** The output can be cut at once, or it can wait for the next falling edge of the divided clock.

Turning the output back on always waits for a falling edge. The output therefore never shows a shortened pulse when it resumes.

A drive-enable flag models the pad's tri-state control. The clock line reads low whenever the flag is low.

Top module: `clkout_gate_div`

## Requirements
- R1: With `cfg_div_sel` = k (0..7), the output is high for 2^k source ticks and then low for 2^k source ticks.
- R2: `cfg_src_ref` = 1 feeds the divider from `ref_tick`, and 0 feeds it from `pll_tick`.
- R3: During reset, `clk_out`, `out_drive` and `lock_err` are all 0.
- R4: With `cfg_async_off` = 1, a low on `off_req_n` forces `out_drive` and `clk_out` to 0 in the same cycle, without passing through any register.
- R5: With `cfg_async_off` = 0, a low on `off_req_n` first passes a two-flop synchronizer. `out_drive` then falls in the same cycle as a falling edge of the divided clock, so the last high pulse is full length.
- R6: After `off_req_n` returns high, `out_drive` rises only together with a falling edge of the divided clock. The first low phase after that is full length.
- R7: With `cfg_pd_mode` = 0 (output-enable mode), `src_run` stays 1 while the output is disabled.
- R8: With `cfg_pd_mode` = 1 (power-down mode), `src_run` is 0 while the pin is low. After the pin returns high, both `src_run` and `out_drive` stay 0 until `pll_locked` is 1.
- R9: If `pll_locked` stays 0 for LOCK_TO cycles of waiting after a power-down, `lock_err` goes to 1. It clears when lock arrives or the pin goes low again.
- R10: A change of `cfg_div_sel` or `cfg_src_ref` restarts the divider at low. The output stays low for 2 + 2^k source ticks before its first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pll_tick | input | 1 | One pulse per PLL clock edge |
| ref_tick | input | 1 | One pulse per reference clock edge |
| pll_locked | input | 1 | PLL lock indication |
| cfg_src_ref | input | 1 | 1 selects the reference source, 0 selects the PLL |
| cfg_div_sel | input | 3 | Post-divide exponent k, giving a ratio of 2^k |
| cfg_pd_mode | input | 1 | 1 = power-down mode, 0 = output-enable mode |
| cfg_async_off | input | 1 | 1 = immediate disable, 0 = edge-aligned disable |
| off_req_n | input | 1 | Asynchronous pin; a low requests the output off |
| clk_out | output | 1 | Gated divided clock |
| out_drive | output | 1 | Pad drive enable; 0 models high-Z with a weak low |
| src_run | output | 1 | Source and divider are allowed to run |
| lock_err | output | 1 | Relock timeout flag |

## Verification
- **Immediate disable.** The result is combinational, so it is checked 1 ns after the pin moves, within the same cycle.
- **Edge-aligned results.** The disable, the re-enable and the divide ratio all land on divider edges, and the synchronizer adds two to three cycles before them. The bench does not count a fixed latency for these. It samples at every falling system-clock edge, tracks the run lengths of high and low, and checks them at the cycle where `out_drive` changes: a full high run of 2^k before disable, and a full low run of 2^k after enable.
- **Configuration change.** The low run is counted from the first sample after the change, and it must be exactly 2 + 2^k.
- **Relock timeout.** The synchronizer and the state register add a few cycles of entry skew. The flag is therefore checked at LOCK_TO - 20 and LOCK_TO + 20 cycles after release.

// File: rtl/ckgate_pkg.sv
package ckgate_pkg;
  typedef enum logic [2:0] {
    GS_ON     = 3'd0,
    GS_DRAIN  = 3'd1,
    GS_OFF    = 3'd2,
    GS_RELOCK = 3'd3,
    GS_ARM    = 3'd4
  } gate_st_t;
endpackage

// File: rtl/ckd_src_div.sv
module ckd_src_div #(
  parameter int DIV_W      = 3,
  parameter int HOLD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             pll_tick,
  input  logic             ref_tick,
  output logic             div_clk,
  output logic             fall_evt
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam int HW    = $clog2(HOLD_TICKS + 1);

  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] ratio_m1;
  logic [CNT_W-1:0] cnt;
  logic [HW-1:0]    hold;
  logic [DIV_W:0]   cfg_q;
  logic             cfg_chg;
  logic             tick;
  logic             term;

  assign tick     = src_sel ? ref_tick : pll_tick;
  assign ratio    = (CNT_W+1)'(1) << div_sel;
  assign ratio_m1 = CNT_W'(ratio - (CNT_W+1)'(1));
  assign cfg_chg  = (cfg_q != {src_sel, div_sel});
  assign term     = (cnt == ratio_m1);
  assign fall_evt = run && !cfg_chg && tick && (hold == '0) && term && div_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_clk <= 1'b0;
      hold    <= HW'(HOLD_TICKS);
      cfg_q   <= '0;
    end else begin
      cfg_q <= {src_sel, div_sel};
      if (cfg_chg) begin
        cnt     <= '0;
        div_clk <= 1'b0;
        hold    <= HW'(HOLD_TICKS);
      end else if (!run) begin
        cnt     <= '0;
        div_clk <= 1'b0;
      end else if (tick) begin
        if (hold != '0) begin
          hold <= hold - HW'(1);
        end else if (term) begin
          cnt     <= '0;
          div_clk <= ~div_clk;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_chg |-> (cnt <= ratio_m1));

  // R10
  cfg_restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!div_clk && hold != '0));
endmodule

// File: rtl/ckd_sync.sv
module ckd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/ckd_gate.sv
module ckd_gate
  import ckgate_pkg::*;
#(
  parameter int LOCK_TO = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic async_off,
  input  logic pd_mode,
  input  logic pll_locked,
  input  logic fall_evt,
  input  logic div_clk,
  output logic gate_on,
  output logic src_run,
  output logic lock_err
);
  localparam int TW = $clog2(LOCK_TO + 1);

  gate_st_t      st, nxt;
  logic [TW-1:0] tmr;

  always_comb begin
    nxt = st;
    unique case (st)
      GS_ON:     if (!en_s) nxt = async_off ? GS_OFF : GS_DRAIN;
      GS_DRAIN:  if (en_s) nxt = GS_ON;
                 else if (fall_evt) nxt = GS_OFF;
      GS_OFF:    if (en_s) nxt = pd_mode ? GS_RELOCK : GS_ARM;
      GS_RELOCK: if (!en_s) nxt = GS_OFF;
                 else if (pll_locked) nxt = GS_ARM;
      GS_ARM:    if (!en_s) nxt = GS_OFF;
                 else if (fall_evt) nxt = GS_ON;
      default:   nxt = GS_ARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= GS_ARM;
      gate_on  <= 1'b0;
      tmr      <= '0;
      lock_err <= 1'b0;
    end else begin
      st      <= nxt;
      gate_on <= (nxt == GS_ON) || (nxt == GS_DRAIN);
      if (st == GS_RELOCK && nxt == GS_RELOCK) begin
        if (tmr != TW'(LOCK_TO)) tmr <= tmr + TW'(1);
        if (tmr == TW'(LOCK_TO - 1)) lock_err <= 1'b1;
      end else begin
        tmr      <= '0;
        lock_err <= 1'b0;
      end
    end
  end

  assign src_run = !(pd_mode && (st == GS_OFF || st == GS_RELOCK));

  // R6
  enable_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on) |-> !div_clk);

  // R5
  sync_off_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_on) && !async_off && !$past(async_off)) |-> $fell(div_clk));

  // R8
  relock_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_RELOCK && !pll_locked) |=> !gate_on);

  // R9
  err_only_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_err) |-> ($past(st) == GS_RELOCK));
endmodule

// File: rtl/clkout_gate_div.sv
module clkout_gate_div #(
  parameter int DIV_W       = 3,
  parameter int LOCK_TO     = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pll_tick,
  input  logic             ref_tick,
  input  logic             pll_locked,
  input  logic             cfg_src_ref,
  input  logic [DIV_W-1:0] cfg_div_sel,
  input  logic             cfg_pd_mode,
  input  logic             cfg_async_off,
  input  logic             off_req_n,
  output logic             clk_out,
  output logic             out_drive,
  output logic             src_run,
  output logic             lock_err
);
  logic en_s;
  logic div_clk;
  logic fall_evt;
  logic gate_on;

  ckd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (off_req_n),
    .dout (en_s)
  );

  ckd_src_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (src_run),
    .src_sel (cfg_src_ref),
    .div_sel (cfg_div_sel),
    .pll_tick(pll_tick),
    .ref_tick(ref_tick),
    .div_clk (div_clk),
    .fall_evt(fall_evt)
  );

  ckd_gate #(.LOCK_TO(LOCK_TO)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .async_off (cfg_async_off),
    .pd_mode   (cfg_pd_mode),
    .pll_locked(pll_locked),
    .fall_evt  (fall_evt),
    .div_clk   (div_clk),
    .gate_on   (gate_on),
    .src_run   (src_run),
    .lock_err  (lock_err)
  );

  // immediate path: the raw pin bypasses the synchronizer
  assign out_drive = gate_on & ~(cfg_async_off & ~off_req_n);
  assign clk_out   = div_clk & out_drive;
endmodule

// File: tb/test_clkout_gate_div.sv
module test_clkout_gate_div;
  localparam int LOCK_TO = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_tick = 1'b1;
  logic       ref_tick = 1'b0;
  logic       pll_locked = 1'b1;
  logic       cfg_src_ref = 1'b0;
  logic [2:0] cfg_div_sel = 3'd0;
  logic       cfg_pd_mode = 1'b0;
  logic       cfg_async_off = 1'b0;
  logic       off_req_n = 1'b1;
  logic       clk_out, out_drive, src_run, lock_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  clkout_gate_div #(.LOCK_TO(LOCK_TO)) i_clkout_gate_div (
    .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .ref_tick(ref_tick),
    .pll_locked(pll_locked), .cfg_src_ref(cfg_src_ref), .cfg_div_sel(cfg_div_sel),
    .cfg_pd_mode(cfg_pd_mode), .cfg_async_off(cfg_async_off), .off_req_n(off_req_n),
    .clk_out(clk_out), .out_drive(out_drive), .src_run(src_run), .lock_err(lock_err)
  );

  always #2 clk = ~clk;

  initial begin
    int rc;
    rc = 0;
    forever begin
      @(negedge clk);
      rc = (rc == 2) ? 0 : rc + 1;
      ref_tick = (rc == 0);
    end
  end

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic meas(output int hi, output int lo);
    int g;
    g = 0;
    while (clk_out && g < 4000) begin step(); g++; end
    while (!clk_out && g < 8000) begin step(); g++; end
    hi = 0;
    while (clk_out && hi < 4000) begin hi++; step(); end
    lo = 0;
    while (!clk_out && lo < 4000) begin lo++; step(); end
  endtask

  task automatic wait_drive(input logic v, output int waited);
    waited = 0;
    while (out_drive !== v && waited < 4000) begin step(); waited++; end
  endtask

  task automatic t_reset();
    step(3);
    chk("R3 clk_out", int'(clk_out), 0);
    chk("R3 out_drive", int'(out_drive), 0);
    chk("R3 lock_err", int'(lock_err), 0);
    rst_n = 1'b1;
    step(10);
  endtask

  task automatic t_ratio(int k);
    int hi, lo;
    cfg_div_sel = 3'(k);
    meas(hi, lo);
    chk($sformatf("R1 high k=%0d", k), hi, 1 << k);
    chk($sformatf("R1 low k=%0d", k), lo, 1 << k);
  endtask

  task automatic t_src();
    int hi, lo;
    cfg_src_ref = 1'b1;
    cfg_div_sel = 3'd1;
    meas(hi, lo);
    chk("R2 ref high", hi, 6);
    chk("R2 ref low", lo, 6);
    cfg_src_ref = 1'b0;
    meas(hi, lo);
    chk("R2 pll high", hi, 2);
  endtask

  task automatic t_cfg_change(int k);
    int lo;
    step(5);
    cfg_div_sel = 3'(k);
    step();
    lo = 0;
    while (!clk_out && lo < 4000) begin lo++; step(); end
    chk($sformatf("R10 low after change k=%0d", k), lo, 2 + (1 << k));
  endtask

  task automatic t_async_oe();
    int w, lo;
    cfg_div_sel = 3'd2;
    cfg_async_off = 1'b1;
    cfg_pd_mode = 1'b0;
    step(20);
    while (!clk_out) step();
    off_req_n = 1'b0;
    #1;
    chk("R4 clk_out immediate", int'(clk_out), 0);
    chk("R4 out_drive immediate", int'(out_drive), 0);
    step(20);
    chk("R7 src_run in OE off", int'(src_run), 1);
    chk("R7 clk_out held low", int'(clk_out), 0);
    off_req_n = 1'b1;
    wait_drive(1'b1, w);
    chk("R6 enable bounded", int'(w <= 12), 1);
    chk("R6 clk low at enable", int'(clk_out), 0);
    lo = 0;
    while (!clk_out && lo < 4000) begin lo++; step(); end
    chk("R6 first low full", lo, 4);
  endtask

  task automatic t_sync_off();
    int hi;
    bit prev;
    cfg_async_off = 1'b0;
    cfg_pd_mode = 1'b0;
    cfg_div_sel = 3'd2;
    step(20);
    while (!clk_out) step();
    step();
    off_req_n = 1'b0;
    #1;
    chk("R5 no immediate cut", int'(out_drive), 1);
    hi = 2;
    prev = clk_out;
    for (int i = 0; i < 100 && out_drive; i++) begin
      prev = clk_out;
      step();
      if (out_drive) hi = clk_out ? hi + 1 : 0;
    end
    chk("R5 off reached", int'(out_drive), 0);
    chk("R5 last high before off", int'(prev), 1);
    chk("R5 last pulse full", hi, 4);
    step(10);
    off_req_n = 1'b1;
    step(30);
  endtask

  task automatic t_powerdown();
    int w, lo;
    cfg_async_off = 1'b1;
    cfg_pd_mode = 1'b1;
    cfg_div_sel = 3'd1;
    step(10);
    pll_locked = 1'b0;
    off_req_n = 1'b0;
    step(5);
    chk("R8 src_run halted", int'(src_run), 0);
    off_req_n = 1'b1;
    step(50);
    chk("R8 drive waits lock", int'(out_drive), 0);
    chk("R8 src_run waits lock", int'(src_run), 0);
    chk("R9 no early err", int'(lock_err), 0);
    pll_locked = 1'b1;
    wait_drive(1'b1, w);
    chk("R8 drive after lock", int'(out_drive), 1);
    lo = 0;
    while (!clk_out && lo < 4000) begin lo++; step(); end
    chk("R6 low after relock", lo, 2);
  endtask

  task automatic t_timeout();
    int w;
    pll_locked = 1'b0;
    off_req_n = 1'b0;
    step(5);
    off_req_n = 1'b1;
    step(LOCK_TO - 20);
    chk("R9 err not yet", int'(lock_err), 0);
    step(40);
    chk("R9 err after timeout", int'(lock_err), 1);
    chk("R9 drive still off", int'(out_drive), 0);
    pll_locked = 1'b1;
    step(2);
    chk("R9 err cleared on lock", int'(lock_err), 0);
    wait_drive(1'b1, w);
    chk("R9 drive returns", int'(out_drive), 1);
  endtask

  initial begin
    t_reset();
    t_ratio(0);
    t_ratio(1);
    t_ratio(3);
    t_ratio(7);
    t_src();
    t_cfg_change(2);
    t_cfg_change(0);
    t_async_oe();
    t_sync_off();
    t_powerdown();
    t_timeout();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule